// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, A and B, and moves data in either direction. Each direction owns a storage register. The A-side register captures the A bus, and its contents can be sent to B. The B-side register captures the B bus, and its contents can be sent to A. For each direction a select input chooses what reaches the far bus: the live value from the opposite bus, or the value held in that direction's register. Each direction also has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low, so one control state leaves both buses isolated.

Every bus pin is split into three signals: an input, an output value and an output enable. The logic therefore stays synthesizable, and the tri-state resolution is left to the pad ring or to a wrapper. Each register capture strobe is an enable within the single system clock domain. A register always stores the value seen on its own pin, even when the block itself is driving that pin. This lets one direction be looped back into the other register.

Top module: `dual_reg_transceiver`

## Requirements
- R1: A synchronous active-low reset clears both storage registers to zero. After reset, with both selects high, both data outputs read 8'h00.
- R2: `b_oe` is all ones when `ab_drive` is 1 and all zeros when it is 0.
- R3: `a_oe` is all ones when `ba_drive_n` is 0 and all zeros when it is 1. With `ab_drive`=0 and `ba_drive_n`=1, neither bus is driven.
- R4: When a direction's select is 0, its data output equals the live input of the opposite bus in the same cycle: `b_out`=`a_in` and `a_out`=`b_in`.
- R5: When a direction's select is 1, its data output equals that direction's stored register: `b_out` is the A-side register and `a_out` is the B-side register.
- R6: On a clock edge with `a_load`=1, the A-side register takes `a_in`. On a clock edge with `b_load`=1, the B-side register takes `b_in`. This holds for every value of the enables and selects. With its strobe at 0, a register holds its value.
- R7: With both selects at 1, the A-side register reaches `b_out` and the B-side register reaches `a_out` at the same time.
- R8: A register captures its pin even when the block drives that pin. When A is driven with real-time B data, loading the A-side register stores that B data.
- R9: With both selects at 0, the two registers can be loaded on the same edge, and each one keeps its own bus value.
- R10: When the live and stored values of a direction are equal, toggling that direction's select leaves its data output unchanged.
- R11: With both directions enabled in real-time mode and no external driver, each bus driven back through the block keeps its last value when a bus holder is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Resolved value of the A bus pins |
| a_out | output | 8 | Value offered to the A bus pins |
| a_oe | output | 8 | Per-pin drive enable for the A bus |
| b_in | input | 8 | Resolved value of the B bus pins |
| b_out | output | 8 | Value offered to the B bus pins |
| b_oe | output | 8 | Per-pin drive enable for the B bus |
| ab_drive | input | 1 | A-to-B drive enable, active high |
| ba_drive_n | input | 1 | B-to-A drive enable, active low |
| ab_use_store | input | 1 | A-to-B select: 0 live, 1 stored |
| ba_use_store | input | 1 | B-to-A select: 0 live, 1 stored |
| a_load | input | 1 | Capture strobe for the A-side register |
| b_load | input | 1 | Capture strobe for the B-side register |

## Verification
The hardest cases to reach are the ones where a pin is fed by the block itself, with no external driver. These are the loop-back capture and the bus-holder case. The bench reaches them in two steps. It first drives one bus externally while the block copies that value across. It then releases the external driver, so that the resolved pin value comes only from the block's own output and the modelled holder. After that it strobes the register, or waits several cycles, and reads the result back through the stored-data path. A full sweep of all sixteen enable and select combinations, with loads issued under each combination, covers the control decoding.

// File: rtl/xcvr_pkg.sv
// Package: shared types for the registered transceiver.
// Assumes: one lane per transfer direction, all in one clock domain.
package xcvr_pkg;

    // Number of transfer directions and their lane indices
    localparam int NDIR   = 2;
    localparam int DIR_AB = 0;
    localparam int DIR_BA = 1;

    // Per-lane control: capture strobe, source select, drive enable (active high)
    typedef struct packed {
        logic load;
        logic use_store;
        logic drive;
    } lane_ctrl_t;

endpackage

// File: rtl/xcvr_store_reg.sv
// Module: xcvr_store_reg
// Storage register for one transfer direction. It captures the resolved pin
// value of its own bus on any clock edge where load is high.
// Assumes: synchronous active-low reset, load is a one-clock enable strobe.
module xcvr_store_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture pin data on strobe; clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> q == '0); // R1
    AST_CAPTURE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d)); // R6
    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q)); // R6

endmodule

// File: rtl/xcvr_path_mux.sv
// Module: xcvr_path_mux
// Chooses live or stored data for one direction. Each bit is an AND-OR network
// with a consensus term, so a select change cannot glitch a bit whose two
// sources agree.
// Assumes: sel = 0 selects live data, sel = 1 selects stored data.
module xcvr_path_mux #(
    parameter int W = 8
) (
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] y
);

    genvar i;
    for (i = 0; i < W; i++) begin : g_bit
        // Hazard-free two-input select with consensus term
        assign y[i] = (~sel & live[i]) | (sel & stored[i]) | (live[i] & stored[i]);
    end

    // Guard the selection semantics and the no-glitch property
    always_comb begin
        if (!sel) begin
            AST_LIVE_PASS: assert (y == live); // R4
        end
        if (sel) begin
            AST_STORED_PASS: assert (y == stored); // R5
        end
        if (live == stored) begin
            AST_NO_GLITCH: assert (y == live); // R10
        end
    end

endmodule

// File: rtl/xcvr_lane.sv
// Module: xcvr_lane
// One transfer direction: source-side register, live/stored select and the
// drive enables for the destination bus pins.
// Assumes: src is the resolved pin value of the source bus, including any
// value this block itself drives onto it.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst_out,
    output logic [W-1:0] dst_oe,
    output logic [W-1:0] stored
);

    xcvr_store_reg #(.W(W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ctrl.load),
        .d     (src),
        .q     (stored)
    );

    xcvr_path_mux #(.W(W)) u_mux (
        .sel    (ctrl.use_store),
        .live   (src),
        .stored (stored),
        .y      (dst_out)
    );

    // Replicate the direction enable onto every destination pin
    assign dst_oe = {W{ctrl.drive}};

endmodule

// File: rtl/dual_reg_transceiver.sv
// Module: dual_reg_transceiver
// Registered bidirectional transceiver between buses A and B. It has one
// storage register and one live/stored select per direction. A-to-B drive is
// active high and B-to-A drive is active low.
// Assumes: pins are split into in/out/oe; an external resolver feeds back
// the pin value, and both capture strobes are synchronous to clk.
module dual_reg_transceiver
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         ab_drive,
    input  logic         ba_drive_n,
    input  logic         ab_use_store,
    input  logic         ba_use_store,
    input  logic         a_load,
    input  logic         b_load
);

    lane_ctrl_t       ctl     [NDIR];
    logic [W-1:0]     src_bus [NDIR];
    logic [W-1:0]     dst_bus [NDIR];
    logic [W-1:0]     dst_en  [NDIR];
    logic [W-1:0]     held    [NDIR];

    // Map port controls to lanes; the B-to-A enable polarity is inverted here
    assign ctl[DIR_AB] = '{load: a_load, use_store: ab_use_store, drive: ab_drive};
    assign ctl[DIR_BA] = '{load: b_load, use_store: ba_use_store, drive: ~ba_drive_n};

    // Each lane samples its own bus and drives the opposite one
    assign src_bus[DIR_AB] = a_in;
    assign src_bus[DIR_BA] = b_in;
    assign b_out = dst_bus[DIR_AB];
    assign b_oe  = dst_en[DIR_AB];
    assign a_out = dst_bus[DIR_BA];
    assign a_oe  = dst_en[DIR_BA];

    genvar d;
    for (d = 0; d < NDIR; d++) begin : g_lane
        xcvr_lane #(.W(W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctrl    (ctl[d]),
            .src     (src_bus[d]),
            .dst_out (dst_bus[d]),
            .dst_oe  (dst_en[d]),
            .stored  (held[d])
        );
    end

    AST_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_drive && ba_drive_n) |-> (a_oe == '0 && b_oe == '0)); // R3
    AST_AB_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ab_drive |-> (&b_oe)); // R2
    AST_DUAL_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_use_store && ba_use_store) |-> (b_out == held[DIR_AB] && a_out == held[DIR_BA])); // R7
    AST_LOOPBACK_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (a_load && a_oe[0] && !ba_use_store) |=> held[DIR_AB] == $past(a_in)); // R8

endmodule

// File: tb/tb_dual_reg_transceiver.sv
// Bench for dual_reg_transceiver. A wrapper resolves each bus: an external
// driver wins, otherwise the block's drive, otherwise a bus holder. The block
// sees the external value or the held value, which breaks the real-time loop.
module tb_dual_reg_transceiver;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         ab_drive = 1'b0, ba_drive_n = 1'b1;
    logic         ab_use_store = 1'b0, ba_use_store = 1'b0;
    logic         a_load = 1'b0, b_load = 1'b0;
    logic         xa_en = 1'b1, xb_en = 1'b1;
    logic [W-1:0] ext_a = '0, ext_b = '0;
    logic [W-1:0] keep_a = '0, keep_b = '0;
    logic [W-1:0] a_bus, b_bus, a_pin, b_pin;
    int           checks = 0;
    int           errors = 0;

    always #10 clk = ~clk;

    // Resolved bus values: external driver, then block drive, then holder
    assign a_bus = xa_en ? ext_a : (a_oe[0] ? a_out : keep_a);
    assign b_bus = xb_en ? ext_b : (b_oe[0] ? b_out : keep_b);
    assign a_pin = xa_en ? ext_a : keep_a;
    assign b_pin = xb_en ? ext_b : keep_b;

    // Bus holder remembers each bus's last resolved value
    always_ff @(posedge clk) begin
        keep_a <= a_bus;
        keep_b <= b_bus;
    end

    dual_reg_transceiver #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_pin), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_pin), .b_out(b_out), .b_oe(b_oe),
        .ab_drive(ab_drive), .ba_drive_n(ba_drive_n),
        .ab_use_store(ab_use_store), .ba_use_store(ba_use_store),
        .a_load(a_load), .b_load(b_load)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic readback(input string req, input logic [W-1:0] ea, input logic [W-1:0] eb);
        ab_drive = 1'b1; ba_drive_n = 1'b0; ab_use_store = 1'b1; ba_use_store = 1'b1;
        #1;
        chk(req, b_out, ea);
        chk(req, a_out, eb);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] ra, rb, la, lb, v;
        logic [3:0]   cb;
        step(); step();
        rst_n = 1'b1;
        ext_a = 8'h9C; ext_b = 8'h63;
        readback("R1 reset clears", 8'h00, 8'h00);

        // R2 R3 R4 R5 R6 R7: all control combinations with loads under each one
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 16; c++) begin
                cb = c[3:0];
                ra = 8'(p * 53 + c * 7 + 11);
                rb = ~ra;
                la = ra ^ 8'h5A;
                lb = 8'(ra + 8'd17);
                xa_en = 1'b1; xb_en = 1'b1;
                ab_drive = cb[0]; ba_drive_n = cb[1];
                ab_use_store = cb[2]; ba_use_store = cb[3];
                ext_a = ra; ext_b = rb; a_load = 1'b1; b_load = 1'b1;
                step();
                a_load = 1'b0; b_load = 1'b0;
                ext_a = la; ext_b = lb;
                #1;
                chk("R2 ab enable", b_oe, {W{cb[0]}});
                chk("R3 ba enable", a_oe, {W{~cb[1]}});
                if (cb[0]) chk(cb[2] ? "R5 stored to B" : "R4 live to B", b_out, cb[2] ? ra : la);
                if (!cb[1]) chk(cb[3] ? "R5 stored to A" : "R4 live to A", a_out, cb[3] ? rb : lb);
                step();
                readback("R6 R7 capture and hold", ra, rb);
            end
        end

        // R1: reset after loading clears both registers
        ext_a = 8'h77; ext_b = 8'h88; a_load = 1'b1; b_load = 1'b1;
        step();
        a_load = 1'b0; b_load = 1'b0; rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        readback("R1 reset after load", 8'h00, 8'h00);

        // R9: simultaneous loads in real-time mode
        ab_use_store = 1'b0; ba_use_store = 1'b0; ab_drive = 1'b1; ba_drive_n = 1'b0;
        ext_a = 8'h12; ext_b = 8'hED; a_load = 1'b1; b_load = 1'b1;
        step();
        a_load = 1'b0; b_load = 1'b0;
        readback("R9 simultaneous load", 8'h12, 8'hED);

        // R8: A driven with live B data by the block, then A register loaded
        xa_en = 1'b0; xb_en = 1'b1; ext_b = 8'hC3;
        ab_drive = 1'b0; ba_drive_n = 1'b0; ba_use_store = 1'b0; ab_use_store = 1'b0;
        step(); step();
        a_load = 1'b1;
        step();
        a_load = 1'b0;
        ab_drive = 1'b1; ab_use_store = 1'b1;
        #1;
        chk("R8 loop-back capture", b_out, 8'hC3);

        // R10: toggling select with equal sources keeps the output steady
        xa_en = 1'b1;
        for (int k = 0; k < 3; k++) begin
            v = 8'(k * 85 + 15);
            ext_a = v; a_load = 1'b1;
            step();
            a_load = 1'b0; ab_drive = 1'b1;
            for (int t = 0; t < 6; t++) begin
                ab_use_store = t[0];
                #1;
                chk("R10 select toggle", b_out, v);
            end
        end

        // R11: both directions real-time, external drivers released, holder keeps value
        ab_use_store = 1'b0; ba_use_store = 1'b0; ab_drive = 1'b1; ba_drive_n = 1'b0;
        xa_en = 1'b1; xb_en = 1'b0; ext_a = 8'h4B;
        step(); step();
        xa_en = 1'b0;
        for (int n = 0; n < 5; n++) step();
        chk("R11 A bus held", a_bus, 8'h4B);
        chk("R11 B bus held", b_bus, 8'h4B);
        chk("R11 B output echoes", b_out, 8'h4B);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule